// File: doc/BRIEF.md
# Shared Transmit/Receive Word FIFO

This block is the data buffer between a host register interface and a serial flash shifter. One storage array of 32-bit words serves both directions. The direction input selects the role. In transmit mode the host writes words through a data port and the shifter takes them out one byte at a time. In receive mode the shifter delivers bytes, the block packs them into words, and the host reads those words through the same data port.

Both water levels come from a single occupancy count: the free space for transmit and the fill for receive. Two sticky error flags record a host write into a full buffer and a host read from an empty one. A soft-reset request empties the buffer and clears the partial byte position in both directions. The shifter can end a transfer in the middle of a word. On receive the unused upper bytes of that last word read as zero. On transmit the rest of the word is discarded.

Top module: `shared_word_fifo`

## Requirements
- R1: After reset, and always afterwards, `stat_rx_level` equals the number of stored words (0 to DEPTH). `stat_tx_level` equals DEPTH minus that number. `stat_tx_empty` and `stat_rx_empty` are 1 exactly when no word is stored. After reset the levels are 0 and 16, with the default DEPTH of 16.
- R2: In transmit mode (`cmd_dir`=0), words written by the host leave through `shf_tx_byte` in write order. Each word is sent least significant byte first: bits 7:0, then 15:8, then 23:16, then 31:24. The word is removed when its fourth byte is taken.
- R3: A host write in transmit mode while DEPTH words are stored is dropped and sets `stat_tx_ovf`.
- R4: A host read in receive mode (`cmd_dir`=1) while the buffer is empty returns zero on `host_rdata`, removes nothing and sets `stat_rx_udf`.
- R5: Both error flags stay set until cleared. Writing 1 to `flag_clr[0]` clears the overflow flag and 1 to `flag_clr[1]` clears the underflow flag. If a new error occurs in the same cycle as its clear, the flag stays set.
- R6: In receive mode, shifter bytes are packed little-endian: the first byte goes to bits 7:0. `host_rdata` shows the oldest word, and a host read removes it.
- R7: A received byte marked with `shf_rx_last` completes its word early. The byte lanes above it read as zero, and the next byte starts a new word at bits 7:0.
- R8: A transmit byte taken with `shf_tx_last` removes its word early, and the next word starts from bits 7:0.
- R9: Setting `srst_set` raises `srst_busy` for exactly one cycle. When it falls, the buffer is empty and both byte positions are back to lane 0.
- R10: A host write in receive mode and a host read in transmit mode have no effect on contents, levels or flags. `host_rdata` is zero in transmit mode. `shf_tx_valid` is raised only in transmit mode with a word stored.
- R11: `shf_rx_ready` is 1 only in receive mode, outside the soft-reset cycle, with fewer than DEPTH words stored. Bytes offered while it is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_dir | input | 1 | Active command direction: 0 transmit, 1 receive |
| host_wr_en | input | 1 | Host write strobe to the data port |
| host_wdata | input | 32 | Host write word |
| host_rd_en | input | 1 | Host read strobe from the data port |
| host_rdata | output | 32 | Oldest word in receive mode, zero otherwise |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 underflow |
| srst_set | input | 1 | Soft-reset request |
| srst_busy | output | 1 | Soft reset in progress, self-clearing |
| stat_tx_empty | output | 1 | No word stored (transmit view) |
| stat_rx_empty | output | 1 | No word stored (receive view) |
| stat_tx_level | output | 5 | Words that can still be written |
| stat_rx_level | output | 5 | Words that can be read |
| stat_tx_ovf | output | 1 | Sticky overflow flag |
| stat_rx_udf | output | 1 | Sticky underflow flag |
| shf_tx_valid | output | 1 | A transmit byte is available |
| shf_tx_byte | output | 8 | Current transmit byte |
| shf_tx_take | input | 1 | Shifter consumes the current byte |
| shf_tx_last | input | 1 | Consumed byte ends the transfer |
| shf_rx_valid | input | 1 | Shifter delivers a byte |
| shf_rx_byte | input | 8 | Received byte |
| shf_rx_last | input | 1 | Delivered byte ends the transfer |
| shf_rx_ready | output | 1 | Room to accept received bytes |

## Verification
Some properties are checked on every cycle. The occupancy stays within range and changes by at most one per cycle. Nothing is pushed into a full array or popped from an empty one. The flags are sticky, the soft-reset pulse lasts one cycle and leaves the array empty, and receive readiness is low when the array is full. A short packed word must carry zero upper lanes. Byte order, word order and the exact values read back can only be shown by the bench scenarios, compared against a queue model. The same holds for dropping lanes on a short transmit word, for the set-over-clear priority and for the direction gating.

// File: rtl/sfifo_pkg.sv
// Shared definitions for the shared transmit/receive word FIFO.
package sfifo_pkg;
    localparam int unsigned BYTE_W = 8;

    // Direction of the active command
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } sfifo_dir_e;
endpackage

// File: rtl/sfifo_store.sv
// Word storage with one occupancy count.
// Assumes the caller never pushes when full nor pops when empty; flush wins.
module sfifo_store #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [CW-1:0]     count
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the pushed word into the array (no reset needed on storage)
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and the shared occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |=> count == $past(count) + 1'b1);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count < CW'(DEPTH));
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/sfifo_tx_unpack.sv
// Transmit side: presents the head word one byte at a time, low lane first.
// Assumes head is valid whenever have_word is high.
module sfifo_tx_unpack #(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned LANES = WORD_W / sfifo_pkg::BYTE_W,
    localparam int unsigned LW    = $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         enable,
    input  logic                         have_word,
    input  logic [WORD_W-1:0]            head,
    input  logic                         take,
    input  logic                         last,
    output logic                         byte_valid,
    output logic [sfifo_pkg::BYTE_W-1:0] byte_out,
    output logic                         pop_word
);
    logic [LW-1:0] lane;

    assign byte_valid = enable && have_word;
    assign byte_out   = sfifo_pkg::BYTE_W'(head >> (32'(lane) * sfifo_pkg::BYTE_W));
    assign pop_word   = byte_valid && take && (lane == LW'(LANES - 1) || last);

    // Track the lane of the next byte to send
    always_ff @(posedge clk) begin
        if (!rst_n || flush)            lane <= '0;
        else if (pop_word)              lane <= '0;
        else if (byte_valid && take)    lane <= lane + 1'b1;
    end
endmodule

// File: rtl/sfifo_rx_pack.sv
// Receive side: packs bytes little-endian into words; a last byte ends the word early.
// Assumes enable already includes room in the storage.
module sfifo_rx_pack #(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned LANES = WORD_W / sfifo_pkg::BYTE_W,
    localparam int unsigned LW    = $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         enable,
    input  logic                         byte_valid,
    input  logic [sfifo_pkg::BYTE_W-1:0] byte_in,
    input  logic                         last,
    output logic [WORD_W-1:0]            word,
    output logic                         push_word
);
    logic [LW-1:0]     lane;
    logic [WORD_W-1:0] acc;
    logic              accept;

    assign accept    = enable && byte_valid;
    assign word      = acc | (WORD_W'(byte_in) << (32'(lane) * sfifo_pkg::BYTE_W));
    assign push_word = accept && (lane == LW'(LANES - 1) || last);

    // Collect lanes until the word completes
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            lane <= '0;
            acc  <= '0;
        end else if (push_word) begin
            lane <= '0;
            acc  <= '0;
        end else if (accept) begin
            lane <= lane + 1'b1;
            acc  <= word;
        end
    end

    p_zero_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_word && lane != LW'(LANES - 1)) |->
        ((word >> ((32'(lane) + 1) * sfifo_pkg::BYTE_W)) == '0));
endmodule

// File: rtl/shared_word_fifo.sv
// Shared transmit/receive word FIFO: one array, direction chosen by cmd_dir.
// Handles host data port, levels, sticky error flags and one-cycle soft flush.
// Assumes cmd_dir is held stable for the length of a command.
module shared_word_fifo #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_dir,
    input  logic                         host_wr_en,
    input  logic [WORD_W-1:0]            host_wdata,
    input  logic                         host_rd_en,
    output logic [WORD_W-1:0]            host_rdata,
    input  logic [1:0]                   flag_clr,
    input  logic                         srst_set,
    output logic                         srst_busy,
    output logic                         stat_tx_empty,
    output logic                         stat_rx_empty,
    output logic [CW-1:0]                stat_tx_level,
    output logic [CW-1:0]                stat_rx_level,
    output logic                         stat_tx_ovf,
    output logic                         stat_rx_udf,
    output logic                         shf_tx_valid,
    output logic [sfifo_pkg::BYTE_W-1:0] shf_tx_byte,
    input  logic                         shf_tx_take,
    input  logic                         shf_tx_last,
    input  logic                         shf_rx_valid,
    input  logic [sfifo_pkg::BYTE_W-1:0] shf_rx_byte,
    input  logic                         shf_rx_last,
    output logic                         shf_rx_ready
);
    import sfifo_pkg::*;

    sfifo_dir_e        dir;
    logic [CW-1:0]     count;
    logic [WORD_W-1:0] head, pk_word, push_data;
    logic              full, empty, push, pop, pk_push, up_pop;
    logic              host_push, host_pop, ovf_hit, udf_hit;

    assign dir   = sfifo_dir_e'(cmd_dir);
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // Route host and shifter sides by the active direction
    assign host_push = (dir == DIR_TX) && host_wr_en && !full;
    assign host_pop  = (dir == DIR_RX) && host_rd_en && !empty;
    assign push      = (dir == DIR_RX) ? pk_push : host_push;
    assign push_data = (dir == DIR_RX) ? pk_word : host_wdata;
    assign pop       = (dir == DIR_RX) ? host_pop : up_pop;
    assign ovf_hit   = (dir == DIR_TX) && host_wr_en && full;
    assign udf_hit   = (dir == DIR_RX) && host_rd_en && empty;

    assign host_rdata    = (dir == DIR_RX && !empty) ? head : '0;
    assign stat_rx_level = count;
    assign stat_tx_level = CW'(DEPTH) - count;
    assign stat_tx_empty = empty;
    assign stat_rx_empty = empty;
    assign shf_rx_ready  = (dir == DIR_RX) && !srst_busy && !full;

    sfifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(srst_busy), .push(push),
        .push_data(push_data), .pop(pop), .head(head), .count(count)
    );

    sfifo_tx_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .flush(srst_busy),
        .enable((dir == DIR_TX) && !srst_busy), .have_word(!empty),
        .head(head), .take(shf_tx_take), .last(shf_tx_last),
        .byte_valid(shf_tx_valid), .byte_out(shf_tx_byte), .pop_word(up_pop)
    );

    sfifo_rx_pack #(.WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .flush(srst_busy), .enable(shf_rx_ready),
        .byte_valid(shf_rx_valid), .byte_in(shf_rx_byte), .last(shf_rx_last),
        .word(pk_word), .push_word(pk_push)
    );

    // Soft reset: request raises busy for one cycle, during which all is flushed
    always_ff @(posedge clk) begin
        if (!rst_n) srst_busy <= 1'b0;
        else        srst_busy <= srst_busy ? 1'b0 : srst_set;
    end

    // Sticky error flags; a new error wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_tx_ovf <= 1'b0;
            stat_rx_udf <= 1'b0;
        end else begin
            stat_tx_ovf <= ovf_hit || (stat_tx_ovf && !flag_clr[0]);
            stat_rx_udf <= udf_hit || (stat_rx_udf && !flag_clr[1]);
        end
    end

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_dir && host_wr_en && stat_rx_level == CW'(DEPTH)) |=> stat_tx_ovf);
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_tx_ovf && !flag_clr[0]) |=> stat_tx_ovf);
    p_udf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rx_udf && !flag_clr[1]) |=> stat_rx_udf);
    p_busy_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |=> (!srst_busy && stat_rx_level == '0));
    p_ready_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_tx_level == '0) |-> !shf_rx_ready);
    p_tx_valid_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shf_tx_valid |-> (!cmd_dir && stat_rx_level != '0));
endmodule

// File: tb/tb_shared_word_fifo.sv
`timescale 1ns/1ps
module tb_shared_word_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WDOG       = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_dir = 1'b0;
    logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  flag_clr = '0;
    logic        srst_set = 1'b0, srst_busy;
    logic        stat_tx_empty, stat_rx_empty, stat_tx_ovf, stat_rx_udf;
    logic [4:0]  stat_tx_level, stat_rx_level;
    logic        shf_tx_valid, shf_tx_take = 1'b0, shf_tx_last = 1'b0;
    logic [7:0]  shf_tx_byte, shf_rx_byte = '0;
    logic        shf_rx_valid = 1'b0, shf_rx_last = 1'b0, shf_rx_ready;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] q[$];
    int          bidx = 0, aidx = 0;
    logic [31:0] acc = '0;
    bit          m_ovf = 0, m_udf = 0, m_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_word_fifo dut (
        .clk(clk), .rst_n(rst_n), .cmd_dir(cmd_dir),
        .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .host_rd_en(host_rd_en), .host_rdata(host_rdata),
        .flag_clr(flag_clr), .srst_set(srst_set), .srst_busy(srst_busy),
        .stat_tx_empty(stat_tx_empty), .stat_rx_empty(stat_rx_empty),
        .stat_tx_level(stat_tx_level), .stat_rx_level(stat_rx_level),
        .stat_tx_ovf(stat_tx_ovf), .stat_rx_udf(stat_rx_udf),
        .shf_tx_valid(shf_tx_valid), .shf_tx_byte(shf_tx_byte),
        .shf_tx_take(shf_tx_take), .shf_tx_last(shf_tx_last),
        .shf_rx_valid(shf_rx_valid), .shf_rx_byte(shf_rx_byte),
        .shf_rx_last(shf_rx_last), .shf_rx_ready(shf_rx_ready)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each clock edge, using the inputs held since the falling edge
    always @(posedge clk) begin : model
        int  sz;
        bit  mfull, mempty, b;
        if (!rst_n) begin
            q.delete(); bidx = 0; aidx = 0; acc = '0;
            m_ovf = 0; m_udf = 0; m_busy = 0;
        end else begin
            sz = q.size(); mfull = (sz == DEPTH); mempty = (sz == 0); b = m_busy;
            if (!cmd_dir && host_wr_en && mfull) m_ovf = 1; else if (flag_clr[0]) m_ovf = 0;
            if (cmd_dir && host_rd_en && mempty) m_udf = 1; else if (flag_clr[1]) m_udf = 0;
            if (b) begin
                q.delete(); bidx = 0; aidx = 0; acc = '0; m_busy = 0;
            end else begin
                m_busy = srst_set;
                if (!cmd_dir) begin
                    if (!mempty && shf_tx_take) begin
                        if (bidx == 3 || shf_tx_last) begin void'(q.pop_front()); bidx = 0; end
                        else bidx++;
                    end
                    if (host_wr_en && !mfull) q.push_back(host_wdata);
                end else begin
                    if (host_rd_en && !mempty) void'(q.pop_front());
                    if (shf_rx_valid && !mfull) begin
                        acc = acc | (32'(shf_rx_byte) << (8 * aidx));
                        if (aidx == 3 || shf_rx_last) begin q.push_back(acc); acc = '0; aidx = 0; end
                        else aidx++;
                    end
                end
            end
        end
    end

    // Compare outputs with the model shortly after each falling edge
    always @(negedge clk) begin : compare
        int  sz;
        bit  vld;
        #1;
        if (rst_n && !done) begin
            sz  = q.size();
            vld = !cmd_dir && sz > 0 && !m_busy;
            chk("R1 rx_level", 32'(stat_rx_level), 32'(sz));
            chk("R1 tx_level", 32'(stat_tx_level), 32'(DEPTH - sz));
            chk("R1 tx_empty", 32'(stat_tx_empty), 32'(sz == 0));
            chk("R1 rx_empty", 32'(stat_rx_empty), 32'(sz == 0));
            chk("R3 R5 ovf flag", 32'(stat_tx_ovf), 32'(m_ovf));
            chk("R4 R5 udf flag", 32'(stat_rx_udf), 32'(m_udf));
            chk("R9 busy", 32'(srst_busy), 32'(m_busy));
            chk("R6 R7 R4 R10 rdata", host_rdata, (cmd_dir && sz > 0) ? q[0] : 32'h0);
            chk("R10 tx_valid", 32'(shf_tx_valid), 32'(vld));
            if (vld) chk("R2 R8 tx_byte", 32'(shf_tx_byte), 32'(8'(q[0] >> (8 * bidx))));
            chk("R11 rx_ready", 32'(shf_rx_ready), 32'(cmd_dir && !m_busy && sz < DEPTH));
        end
    end

    task automatic nxt();
        @(negedge clk);
        host_wr_en = 0; host_rd_en = 0; flag_clr = '0; srst_set = 0;
        shf_tx_take = 0; shf_tx_last = 0; shf_rx_valid = 0; shf_rx_last = 0;
    endtask
    task automatic hwrite(logic [31:0] d); nxt(); host_wr_en = 1; host_wdata = d; endtask
    task automatic hread(); nxt(); host_rd_en = 1; endtask
    task automatic take(bit lst); nxt(); shf_tx_take = 1; shf_tx_last = lst; endtask
    task automatic rxb(logic [7:0] b, bit lst);
        nxt(); shf_rx_valid = 1; shf_rx_byte = b; shf_rx_last = lst;
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1;
        nxt();
        // R1 reset state
        chk("R1 reset tx_level", 32'(stat_tx_level), 32'd16);
        chk("R1 reset rx_level", 32'(stat_rx_level), 32'd0);

        // R2 R8: transmit byte order, early end of a word
        cmd_dir = 0;
        hwrite(32'h44332211); hwrite(32'h88776655); hwrite(32'hCCBBAA99);
        repeat (4) take(0);
        take(0); take(1);
        repeat (4) take(0);
        nxt();
        chk("R2 drained", 32'(stat_rx_level), 32'd0);

        // R3 R5: fill, overflow, set-over-clear, clear
        for (int i = 0; i < DEPTH; i++) hwrite(32'h01010101 * (i + 1));
        hwrite(32'hDEADBEEF);
        nxt(); host_wr_en = 1; host_wdata = 32'hBAD0BAD0; flag_clr = 2'b01;
        nxt(); chk("R5 set wins", 32'(stat_tx_ovf), 32'd1);
        flag_clr = 2'b01;
        nxt(); chk("R5 cleared", 32'(stat_tx_ovf), 32'd0);
        // R10: host read in transmit mode does nothing
        hread(); nxt();
        chk("R10 tx read no pop", 32'(stat_rx_level), 32'd16);

        // R9: soft reset flush, lane restart
        nxt(); srst_set = 1;
        nxt(); nxt();
        chk("R9 flushed", 32'(stat_rx_level), 32'd0);
        hwrite(32'hA3A2A1A0); take(0);
        nxt(); srst_set = 1;
        nxt(); nxt();
        hwrite(32'hB3B2B1B0); nxt();
        chk("R9 lane restart", 32'(shf_tx_byte), 32'hB0);
        take(1);

        // R10: host write in receive mode ignored
        nxt(); cmd_dir = 1;
        hwrite(32'h12345678); nxt();
        chk("R10 rx write ignored", 32'(stat_rx_level), 32'd0);

        // R6 R7: packing and short word
        rxb(8'h11, 0); rxb(8'h22, 0); rxb(8'h33, 0); rxb(8'h44, 0); rxb(8'h55, 1);
        nxt();
        chk("R6 word0", host_rdata, 32'h44332211);
        hread(); nxt();
        chk("R7 short word", host_rdata, 32'h00000055);
        hread();
        // R4: underflow
        hread(); nxt();
        chk("R4 udf", 32'(stat_rx_udf), 32'd1);
        flag_clr = 2'b10; nxt();

        // R11: fill through packer, ready falls, extra byte ignored
        for (int i = 0; i < DEPTH * 4; i++) rxb(8'(i), 0);
        nxt();
        chk("R11 ready low", 32'(shf_rx_ready), 32'd0);
        rxb(8'hEE, 1); nxt();
        chk("R11 ignored", 32'(stat_rx_level), 32'd16);
        for (int i = 0; i < DEPTH; i++) hread();
        nxt(); nxt();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule